// File: doc/BRIEF.md
# Word-Serial Wide Adder Harness

The harness wraps a wide carry-propagate adder so that every adder input and output sits between flip-flops. A host loads the two addends and the incoming carry one 32-bit word at a time through a small write port. It then pulses a launch strobe. The harness captures the adder's sum and carry-out in a result register, and the host fetches that register one word at a time through a read port. Because the adder's inputs and outputs all lie between registers, timing of the adder alone can be measured from register to register. The harness pin count does not grow with the operand width.

The adder inside is a parameterised submodule, and the harness has a single interface that serves every variant. A parameter picks the adder structure: the built-in `+` operator, or an explicit chain of full adders. A second parameter gives the adder's pipeline latency. The harness delays the capture to match that latency, so the host-side protocol is identical for every adder.

Top module: `wadd_harness`

## Requirements
- R1: After reset, `done` is 0 and every readable word (sum words, carry word and unmapped addresses) reads 0.
- R2: A write with `wr_en`=1 stores `wr_data` into the register chosen by `wr_addr`, with NW = OPW/BUSW. Address i < NW loads x bits [BUSW*i +: BUSW]. Address NW+i loads the same slice of y. Address 2*NW loads the carry-in from `wr_data` bit 0.
- R3: A write to an address above 2*NW changes no operand, and it leaves `done` unchanged.
- R4: A `start` pulse sampled at a clock edge makes the result register hold {cout, sum} = x + y + cin of the operands registered at that edge. With LAT = 0 the capture happens on that same edge; otherwise it happens LAT edges later.
- R5: Read address i < NW returns sum bits [BUSW*i +: BUSW]. Address NW returns cout in bit 0 with all other bits 0. Every higher address returns 0. The read path is combinational from the registers.
- R6: `done` rises on the edge after a capture. It falls on the edge after any mapped operand write. When a capture and a mapped write coincide, the capture wins, and the captured result uses the operands as they were before that write.
- R7: The result register keeps its value when operands are written without a new `start`.
- R8: While `wr_en` is 0, activity on `wr_addr` and `wr_data` changes no operand.
- R9: OPW must be a multiple of BUSW, and LAT must not exceed 8. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Operand write strobe |
| wr_addr | input | AW | Operand word address |
| wr_data | input | BUSW | Operand write word |
| start | input | 1 | Launch strobe for one addition |
| rd_addr | input | AW | Result word address |
| rd_data | output | BUSW | Selected result word |
| done | output | 1 | Result register holds a result for the current operands |

## Verification
The addition is tried with several operand patterns, each chosen to expose a different fault:
- Zero operands catch stuck-at-one result bits.
- All-ones plus a carry-in ripples a carry across the full width. The expected sum is zero with a carry-out, so a single broken carry link shows up.
- Complementary alternating patterns with a carry-in have the same full-width propagate, but they start from a different bit phase.
- Maximum plus maximum tests the carry-out with generate on every bit.
- Pseudo-random words catch slice and address mix-ups.

Repeated launches after ignored writes, writes with the strobe low, and a write that coincides with a launch separate the address decode and the capture-versus-write priority from the adder arithmetic.

// File: rtl/wadd_pkg.sv
package wadd_pkg;

   typedef enum logic [1:0] {
      SEL_X    = 2'd0,
      SEL_Y    = 2'd1,
      SEL_CIN  = 2'd2,
      SEL_NONE = 2'd3
   } wsel_e;

   typedef enum int {
      ARCH_BUILTIN = 0,
      ARCH_RIPPLE  = 1
   } arch_e;

   localparam int LAT_MAX = 8;

endpackage

// File: rtl/wadd_opbank.sv
module wadd_opbank
   import wadd_pkg::*;
#(
   parameter int OPW  = 256,
   parameter int BUSW = 32,
   parameter int AW   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [BUSW-1:0] wr_data,
   output logic [OPW-1:0]  op_x,
   output logic [OPW-1:0]  op_y,
   output logic            op_cin,
   output logic            wr_hit
);
   localparam int NW = OPW / BUSW;
   localparam logic [AW-1:0] A_Y   = AW'(NW);
   localparam logic [AW-1:0] A_CIN = AW'(2 * NW);

   wsel_e         sel;
   logic [AW-1:0] slot;

   always_comb begin
      sel  = SEL_NONE;
      slot = '0;
      if (wr_addr < A_Y) begin
         sel  = SEL_X;
         slot = wr_addr;
      end else if (wr_addr < A_CIN) begin
         sel  = SEL_Y;
         slot = wr_addr - A_Y;
      end else if (wr_addr == A_CIN) begin
         sel  = SEL_CIN;
      end
   end

   assign wr_hit = wr_en && (sel != SEL_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_x   <= '0;
         op_y   <= '0;
         op_cin <= 1'b0;
      end else if (wr_en) begin
         for (int w = 0; w < NW; w++) begin
            if (sel == SEL_X && slot == AW'(w)) op_x[w*BUSW +: BUSW] <= wr_data;
            if (sel == SEL_Y && slot == AW'(w)) op_y[w*BUSW +: BUSW] <= wr_data;
         end
         if (sel == SEL_CIN) op_cin <= wr_data[0];
      end
   end

   AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(op_x) && $stable(op_y) && $stable(op_cin))); // R8

   AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr > A_CIN) |=> ($stable(op_x) && $stable(op_y) && $stable(op_cin))); // R3

endmodule

// File: rtl/wadd_core.sv
module wadd_core
   import wadd_pkg::*;
#(
   parameter int OPW  = 256,
   parameter int ARCH = ARCH_RIPPLE,
   parameter int LAT  = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [OPW-1:0] a,
   input  logic [OPW-1:0] b,
   input  logic           ci,
   input  logic           vin,
   output logic [OPW-1:0] s,
   output logic           co,
   output logic           vout
);
   logic [OPW-1:0] s_comb;
   logic           co_comb;

   generate
      if (ARCH == ARCH_BUILTIN) begin : g_builtin
         assign {co_comb, s_comb} = {1'b0, a} + {1'b0, b} + {{OPW{1'b0}}, ci};
      end else begin : g_ripple
         logic [OPW:0] c;
         assign c[0] = ci;
         for (genvar i = 0; i < OPW; i++) begin : g_fa
            assign s_comb[i] = a[i] ^ b[i] ^ c[i];
            assign c[i+1]    = (b[i] & c[i]) | (a[i] & c[i]) | (a[i] & b[i]);
         end
         assign co_comb = c[OPW];
      end

      if (LAT == 0) begin : g_comb
         assign s    = s_comb;
         assign co   = co_comb;
         assign vout = vin;
      end else begin : g_pipe
         logic [OPW:0] stg [LAT];
         logic [LAT-1:0] vld;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld <= '0;
               for (int k = 0; k < LAT; k++) stg[k] <= '0;
            end else begin
               stg[0] <= {co_comb, s_comb};
               vld[0] <= vin;
               for (int k = 1; k < LAT; k++) begin
                  stg[k] <= stg[k-1];
                  vld[k] <= vld[k-1];
               end
            end
         end
         assign {co, s} = stg[LAT-1];
         assign vout    = vld[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/wadd_result.sv
module wadd_result #(
   parameter int OPW  = 256,
   parameter int BUSW = 32,
   parameter int AW   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap,
   input  logic [OPW-1:0]  s,
   input  logic            co,
   input  logic [AW-1:0]   rd_addr,
   output logic [BUSW-1:0] rd_data
);
   localparam int NW = OPW / BUSW;
   localparam logic [AW-1:0] A_CO = AW'(NW);

   logic [OPW-1:0] res_s;
   logic           res_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_s <= '0;
         res_c <= 1'b0;
      end else if (cap) begin
         res_s <= s;
         res_c <= co;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < NW; w++) begin
         if (rd_addr == AW'(w)) rd_data = res_s[w*BUSW +: BUSW];
      end
      if (rd_addr == A_CO) rd_data[0] = res_c;
   end

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> ($stable(res_s) && $stable(res_c))); // R7

   AST_CARRY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == A_CO) |-> (rd_data[BUSW-1:1] == '0)); // R5

   AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr > A_CO) |-> (rd_data == '0)); // R5

endmodule

// File: rtl/wadd_harness.sv
module wadd_harness
   import wadd_pkg::*;
#(
   parameter int OPW  = 256,
   parameter int BUSW = 32,
   parameter int ARCH = ARCH_RIPPLE,
   parameter int LAT  = 0,
   localparam int NW  = OPW / BUSW,
   localparam int AW  = $clog2(2 * NW + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [BUSW-1:0] wr_data,
   input  logic            start,
   input  logic [AW-1:0]   rd_addr,
   output logic [BUSW-1:0] rd_data,
   output logic            done
);
   generate
      if (OPW % BUSW != 0) begin : g_bad_width
         $error("wadd_harness: OPW must be a multiple of BUSW"); // R9
      end
      if (LAT < 0 || LAT > LAT_MAX) begin : g_bad_lat
         $error("wadd_harness: LAT out of range"); // R9
      end
   endgenerate

   logic [OPW-1:0] op_x, op_y, sum;
   logic           op_cin, cout, cap, wr_hit;

   wadd_opbank #(.OPW(OPW), .BUSW(BUSW), .AW(AW)) u_opbank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .op_x(op_x), .op_y(op_y), .op_cin(op_cin),
      .wr_hit(wr_hit)
   );

   wadd_core #(.OPW(OPW), .ARCH(ARCH), .LAT(LAT)) u_core (
      .clk(clk), .rst_n(rst_n), .a(op_x), .b(op_y), .ci(op_cin),
      .vin(start), .s(sum), .co(cout), .vout(cap)
   );

   wadd_result #(.OPW(OPW), .BUSW(BUSW), .AW(AW)) u_result (
      .clk(clk), .rst_n(rst_n), .cap(cap), .s(sum), .co(cout),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      done <= 1'b0;
      else if (cap)    done <= 1'b1;
      else if (wr_hit) done <= 1'b0;
   end

   AST_DONE_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> done); // R6

   AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !cap) |=> !done); // R6

endmodule

// File: tb/test_wadd_harness.sv
`timescale 1ns/100ps
module test_wadd_harness;
   localparam int OPW  = 256;
   localparam int BUSW = 32;
   localparam int NW   = OPW / BUSW;
   localparam int AW   = $clog2(2 * NW + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [BUSW-1:0] wr_data = '0;
   logic            start = 1'b0;
   logic [AW-1:0]   rd_addr = '0;
   logic [BUSW-1:0] rd_data;
   logic            done;

   int total = 0;
   int bad   = 0;
   logic [OPW:0] expq[$];
   bit           mon_busy = 1'b0;
   logic [OPW:0] last_exp;

   always #2 clk = ~clk;

   wadd_harness #(.OPW(OPW), .BUSW(BUSW)) i_wadd_harness (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start(start), .rd_addr(rd_addr),
      .rd_data(rd_data), .done(done)
   );

   task automatic chk(input bit ok, input string req, input logic [BUSW-1:0] act,
                      input logic [BUSW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put_word(input int addr, input logic [BUSW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic launch(input logic [OPW:0] e);
      expq.push_back(e);
      last_exp = e;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait (expq.size() == 0 && !mon_busy);
   endtask

   task automatic run_op(input logic [OPW-1:0] x, input logic [OPW-1:0] y, input logic c);
      for (int w = 0; w < NW; w++) put_word(w, x[w*BUSW +: BUSW]);
      for (int w = 0; w < NW; w++) put_word(NW + w, y[w*BUSW +: BUSW]);
      put_word(2 * NW, {31'b0, c});
      launch({1'b0, x} + {1'b0, y} + {{OPW{1'b0}}, c});   // R2 R4
   endtask

   function automatic logic [OPW-1:0] mix(input int seed);
      logic [31:0] r = 32'h1234_5678 ^ seed;
      logic [OPW-1:0] v;
      for (int w = 0; w < NW; w++) begin
         r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
         v[w*BUSW +: BUSW] = r;
      end
      return v;
   endfunction

   // Monitor: pops the scoreboard on each rising done and reads every word.
   initial begin
      logic prev = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n && done && !prev && expq.size() > 0) begin
            logic [OPW:0] e;
            e = expq.pop_front();
            mon_busy = 1'b1;
            for (int w = 0; w <= NW; w++) begin
               logic [BUSW-1:0] ew;
               ew = (w < NW) ? e[w*BUSW +: BUSW] : {31'b0, e[OPW]};
               rd_addr = AW'(w);
               #1;
               chk(rd_data === ew, (w < NW) ? "R4 sum word" : "R5 carry word", rd_data, ew);
               @(negedge clk);
            end
            mon_busy = 1'b0;
         end
         prev = done;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [OPW-1:0] ones = '1;
      logic [OPW-1:0] alt_a, alt_b;
      for (int w = 0; w < NW; w++) begin
         alt_a[w*BUSW +: BUSW] = 32'hAAAA_AAAA;
         alt_b[w*BUSW +: BUSW] = 32'h5555_5555;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(done === 1'b0, "R1 done after reset", {31'b0, done}, 32'h0);
      for (int w = 0; w <= 2 * NW + 2; w++) begin
         rd_addr = AW'(w);
         #1;
         chk(rd_data === '0, "R1 word after reset", rd_data, 32'h0);
      end

      run_op('0, '0, 1'b0);                  // zero
      run_op(ones, '0, 1'b1);                // full-width carry ripple
      run_op(ones, '0, 1'b0);
      run_op(alt_a, alt_b, 1'b1);            // propagate everywhere
      run_op(ones, ones, 1'b1);              // generate everywhere
      for (int k = 0; k < 4; k++) run_op(mix(k), mix(k + 17), k[0]);

      // R5 unmapped read returns 0
      @(negedge clk);
      rd_addr = AW'(NW + 3);
      #1;
      chk(rd_data === '0, "R5 unmapped read", rd_data, 32'h0);

      // R3 unmapped writes leave operands and done alone
      for (int a = 2 * NW + 1; a < (1 << AW); a++) put_word(a, 32'hDEAD_BEEF);
      #1;
      chk(done === 1'b1, "R3 done kept after unmapped write", {31'b0, done}, 32'h1);
      put_word(2 * NW, {31'b0, last_exp[OPW] ^ last_exp[OPW]} | 32'(mix(3)[0] & 1'b0) | 32'h0);
      // cin for the last op (k=3) was 1; restore it so the expected value stays valid
      put_word(2 * NW, 32'h1);
      #1;
      chk(done === 1'b0, "R6 done cleared by write", {31'b0, done}, 32'h0);
      launch(last_exp);                      // R3 same result

      // R8 bus activity without strobe
      @(negedge clk);
      wr_addr = '0; wr_data = 32'hFFFF_0000;
      @(negedge clk);
      wr_addr = AW'(NW); wr_data = 32'h0F0F_0F0F;
      @(negedge clk);
      put_word(2 * NW, 32'h1);
      launch(last_exp);                      // R8 unchanged operands

      // R7 result held while operands change
      put_word(0, 32'h0000_0001);
      @(negedge clk);
      rd_addr = '0;
      #1;
      chk(rd_data === last_exp[BUSW-1:0], "R7 result held", rd_data, last_exp[BUSW-1:0]);

      // R6 capture and write together: capture wins, old operands used
      begin
         logic [OPW-1:0] x0 = mix(3);
         logic [OPW-1:0] y0 = mix(20);
         logic [OPW:0]   e0;
         x0[BUSW-1:0] = 32'h0000_0001;
         e0 = {1'b0, x0} + {1'b0, y0} + {{OPW{1'b0}}, 1'b1};
         expq.push_back(e0);
         @(negedge clk);
         wr_en = 1'b1; wr_addr = '0; wr_data = 32'hFFFF_FFFF; start = 1'b1;
         @(negedge clk);
         wr_en = 1'b0; start = 1'b0;
         chk(done === 1'b1, "R6 capture beats write", {31'b0, done}, 32'h1);
         wait (expq.size() == 0 && !mon_busy);
      end

      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule